// File: doc/BRIEF.md
# Carrier Detect Qualification Timer

This block sits between the analog level comparator of a low-speed FSK receiver and the rest of the system. It takes a raw "signal present" bit and produces a debounced detect output `sd_n`, which is active low. The detect output changes only after the raw bit has held its new value for a programmed number of millisecond ticks. The delay that sets the output and the delay that clears it are chosen separately. In FSK mode a 2-bit code selects the pair of delays. In call-progress mode the pair is fixed.

The block also gates the demodulated receive data. While `sd_n` is high, the receive data output is forced to mark (1), so line noise cannot look like data. An inactive mode holds `sd_n` high. Power-down holds `sd_n` low and keeps the timers in reset. The millisecond tick comes from outside as a one-cycle strobe, and every delay is counted in those ticks.

Top module: `cd_qual`

## Requirements
- R1: After reset, with mode FSK (`mode`=2'b00), `sd_n` is 1 and `rxd_out` is 1.
- R2: In FSK mode, after `raw_present` rises, `sd_n` falls on the clock edge that samples the Nth tick. N is 450, 15, 15 or 80 for `cd_sel` = 00, 01, 10, 11.
- R3: In FSK mode, after `raw_present` falls, `sd_n` rises on the edge that samples the Nth tick. N is 30, 30, 15 or 10 for `cd_sel` = 00, 01, 10, 11.
- R4: In call-progress mode (`mode`=2'b01), the set delay is 10 ticks and the clear delay is 25 ticks, whatever the value of `cd_sel`.
- R5: The tick count advances only while `raw_present` differs from the detected state. It returns to zero when `raw_present` reverts, so a later change needs the full delay again.
- R6: When `sd_n` is 1, `rxd_out` is 1. When `sd_n` is 0, `rxd_out` equals `rxd_in`.
- R7: In the inactive mode (`mode`=2'b11), `sd_n` is 1 whatever `raw_present` and the tick do.
- R8: In power-down (`mode`=2'b10), `sd_n` is 0 and the detected state is cleared. After power-down ends, detection starts again from "not detected".
- R9: The delays are taken from `cd_sel` as it stood when the current timing run started. A change of `cd_sel` during a run only affects the next run.
- R10: Any change of `mode` clears the detected state and restarts the timer.
- R11: Without a tick, the detected state never changes, except when it is cleared by mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| raw_present | input | 1 | Raw comparator output, 1 = signal above threshold |
| cd_sel | input | 2 | FSK delay-pair select |
| mode | input | 2 | 00 FSK, 01 call-progress, 10 power-down, 11 inactive |
| rxd_in | input | 1 | Demodulated receive data |
| sd_n | output | 1 | Qualified detect, active low |
| rxd_out | output | 1 | Receive data, forced to 1 while `sd_n` is 1 |

## Verification
The assertions assume that `ms_tick` is a single-cycle pulse, and that `raw_present`, `mode` and `cd_sel` are synchronous to `clk`. The stimulus changes every input on the falling clock edge, and it raises the tick for exactly one cycle, with idle cycles between ticks. Because of this, each tick is sampled by exactly one rising edge, and every delay can be counted in whole ticks.

// File: rtl/cd_qual_pkg.sv
package cd_qual_pkg;

  typedef enum logic [1:0] {
    MODE_FSK  = 2'b00,
    MODE_CPT  = 2'b01,
    MODE_PDN  = 2'b10,
    MODE_IDLE = 2'b11
  } cq_mode_e;

  localparam int unsigned CQ_MAX_DELAY = 450;
  localparam int unsigned CQ_CNT_W     = $clog2(CQ_MAX_DELAY + 1);

  // ticks needed before the detected state is set
  function automatic int unsigned set_ticks(input logic cpt, input logic [1:0] sel);
    if (cpt) return 10;
    case (sel)
      2'b00:   return 450;
      2'b01:   return 15;
      2'b10:   return 15;
      default: return 80;
    endcase
  endfunction

  // ticks needed before the detected state is cleared
  function automatic int unsigned clr_ticks(input logic cpt, input logic [1:0] sel);
    if (cpt) return 25;
    case (sel)
      2'b00:   return 30;
      2'b01:   return 30;
      2'b10:   return 15;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/cq_delay_sel.sv
module cq_delay_sel
  import cd_qual_pkg::*;
#(
  parameter int unsigned CNT_W = CQ_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cpt_mode,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] set_lim,
  output logic [CNT_W-1:0] clr_lim
);

  logic [1:0] sel_q;
  logic       cpt_q;

  // sample the selection only while no run is in progress
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      cpt_q <= 1'b0;
    end else if (cap_en) begin
      sel_q <= sel;
      cpt_q <= cpt_mode;
    end
  end

  assign set_lim = CNT_W'(set_ticks(cpt_q, sel_q));
  assign clr_lim = CNT_W'(clr_ticks(cpt_q, sel_q));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(sel_q) && $stable(cpt_q));

endmodule

// File: rtl/cq_timer.sv
module cq_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             raw,
  input  logic [CNT_W-1:0] set_lim,
  input  logic [CNT_W-1:0] clr_lim,
  output logic             det,
  output logic             idle
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             expire;

  assign idle   = (raw == det);
  assign lim    = det ? clr_lim : set_lim;
  assign expire = tick && (cnt == lim - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det <= 1'b0;
      cnt <= '0;
    end else if (clr) begin
      det <= 1'b0;
      cnt <= '0;
    end else if (idle) begin
      cnt <= '0;
    end else if (expire) begin
      det <= raw;
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(det));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && idle) |=> (cnt == '0));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < lim);

endmodule

// File: rtl/cd_qual.sv
module cd_qual
  import cd_qual_pkg::*;
#(
  parameter int unsigned CNT_W = CQ_CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       raw_present,
  input  logic [1:0] cd_sel,
  input  logic [1:0] mode,
  input  logic       rxd_in,
  output logic       sd_n,
  output logic       rxd_out
);

  logic [1:0]       mode_q;
  logic             mode_chg;
  logic             timers_off;
  logic             clr;
  logic             det;
  logic             idle;
  logic [CNT_W-1:0] set_lim;
  logic [CNT_W-1:0] clr_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FSK;
    else        mode_q <= mode;
  end

  assign mode_chg   = (mode != mode_q);
  assign timers_off = (mode == MODE_PDN) || (mode == MODE_IDLE);
  assign clr        = mode_chg || timers_off;

  cq_delay_sel #(.CNT_W(CNT_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (idle || clr),
    .cpt_mode (mode == MODE_CPT),
    .sel      (cd_sel),
    .set_lim  (set_lim),
    .clr_lim  (clr_lim)
  );

  cq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .tick    (ms_tick),
    .raw     (raw_present),
    .set_lim (set_lim),
    .clr_lim (clr_lim),
    .det     (det),
    .idle    (idle)
  );

  always_comb begin
    case (mode)
      MODE_PDN:  sd_n = 1'b0;
      MODE_IDLE: sd_n = 1'b1;
      default:   sd_n = ~det;
    endcase
  end

  assign rxd_out = sd_n | rxd_in;

  p_rxd_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_n |-> rxd_out);

  p_pdn_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PDN) |=> !det);

  p_mode_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> !det);

  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |-> sd_n);

endmodule

// File: tb/cd_qual_tb.sv
module cd_qual_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       raw_present = 1'b0;
  logic [1:0] cd_sel = 2'b00;
  logic [1:0] mode = 2'b00;
  logic       rxd_in = 1'b0;
  logic       sd_n;
  logic       rxd_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cd_qual u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .raw_present(raw_present),
    .cd_sel(cd_sel), .mode(mode), .rxd_in(rxd_in), .sd_n(sd_n), .rxd_out(rxd_out)
  );

  function automatic int fsk_set(input int s);
    int t[4] = '{450, 15, 15, 80};
    return t[s];
  endfunction

  function automatic int fsk_clr(input int s);
    int t[4] = '{30, 30, 15, 10};
    return t[s];
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      idle_cyc(1);
    end
  endtask

  task automatic t_reset_r1;
    check(sd_n, 1'b1, "R1 sd_n");
    check(rxd_out, 1'b1, "R1 rxd_out");
  endtask

  task automatic t_fsk_pair(input int s);
    cd_sel = 2'(s);
    rxd_in = 1'b0;
    idle_cyc(2);
    raw_present = 1'b1;
    ticks(fsk_set(s) - 1);
    check(sd_n, 1'b1, "R2 before set");
    check(rxd_out, 1'b1, "R6 clamp");
    ticks(1);
    check(sd_n, 1'b0, "R2 at set");
    check(rxd_out, 1'b0, "R6 pass 0");
    rxd_in = 1'b1; idle_cyc(1);
    check(rxd_out, 1'b1, "R6 pass 1");
    rxd_in = 1'b0;
    raw_present = 1'b0;
    ticks(fsk_clr(s) - 1);
    check(sd_n, 1'b0, "R3 before clear");
    ticks(1);
    check(sd_n, 1'b1, "R3 at clear");
  endtask

  task automatic t_restart_r5;
    cd_sel = 2'b01; idle_cyc(2);
    raw_present = 1'b1; ticks(14);
    raw_present = 1'b0; idle_cyc(2);
    raw_present = 1'b1; ticks(14);
    check(sd_n, 1'b1, "R5 restarted run");
    ticks(1);
    check(sd_n, 1'b0, "R5 full delay");
    raw_present = 1'b0; ticks(30);
    check(sd_n, 1'b1, "R5 back");
  endtask

  task automatic t_sel_change_r9;
    cd_sel = 2'b01; idle_cyc(2);
    raw_present = 1'b1; ticks(5);
    cd_sel = 2'b00; ticks(9);
    check(sd_n, 1'b1, "R9 old run 14");
    ticks(1);
    check(sd_n, 1'b0, "R9 old run 15");
    raw_present = 1'b0; ticks(29);
    check(sd_n, 1'b0, "R9 new clear 29");
    ticks(1);
    check(sd_n, 1'b1, "R9 new clear 30");
    raw_present = 1'b1; ticks(449);
    check(sd_n, 1'b1, "R9 new set 449");
    ticks(1);
    check(sd_n, 1'b0, "R9 new set 450");
    raw_present = 1'b0; ticks(30);
  endtask

  task automatic t_no_tick_r11;
    cd_sel = 2'b11; idle_cyc(2);
    raw_present = 1'b1; idle_cyc(200);
    check(sd_n, 1'b1, "R11 no tick");
    raw_present = 1'b0; idle_cyc(2);
  endtask

  task automatic t_cpt_r4;
    cd_sel = 2'b00;
    mode = 2'b01; idle_cyc(2);
    raw_present = 1'b1; ticks(9);
    check(sd_n, 1'b1, "R4 set 9");
    ticks(1);
    check(sd_n, 1'b0, "R4 set 10");
    raw_present = 1'b0; ticks(24);
    check(sd_n, 1'b0, "R4 clear 24");
    ticks(1);
    check(sd_n, 1'b1, "R4 clear 25");
  endtask

  task automatic t_mode_chg_r10;
    raw_present = 1'b1; ticks(10);
    check(sd_n, 1'b0, "R10 cpt detected");
    cd_sel = 2'b01; mode = 2'b00; idle_cyc(1);
    check(sd_n, 1'b1, "R10 cleared");
    ticks(14);
    check(sd_n, 1'b1, "R10 rerun 14");
    ticks(1);
    check(sd_n, 1'b0, "R10 rerun 15");
    raw_present = 1'b0; ticks(30);
  endtask

  task automatic t_inactive_r7;
    mode = 2'b11; rxd_in = 1'b0;
    raw_present = 1'b1; ticks(500);
    check(sd_n, 1'b1, "R7 held high");
    check(rxd_out, 1'b1, "R7 rxd clamp");
  endtask

  task automatic t_pdn_r8;
    mode = 2'b10; rxd_in = 1'b1; idle_cyc(1);
    check(sd_n, 1'b0, "R8 pdn low");
    ticks(20);
    check(sd_n, 1'b0, "R8 pdn still low");
    cd_sel = 2'b01; mode = 2'b00; idle_cyc(1);
    check(sd_n, 1'b1, "R8 restart undetected");
    ticks(14);
    check(sd_n, 1'b1, "R8 after pdn 14");
    ticks(1);
    check(sd_n, 1'b0, "R8 after pdn 15");
    raw_present = 1'b0; ticks(30);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_cyc(3);
    rst_n = 1'b1;
    idle_cyc(2);
    t_reset_r1();
    for (int s = 0; s < 4; s++) t_fsk_pair(s);
    t_restart_r5();
    t_sel_change_r9();
    t_no_tick_r11();
    t_cpt_r4();
    t_mode_chg_r10();
    t_inactive_r7();
    t_pdn_r8();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule